// File: doc/BRIEF.md
# Multi-match address sequencer

This block sits behind the per-entry match bits of a content-addressable search array. A search is started with a `start` pulse. The block then captures the match vector and presents four things: the lowest matching entry as an encoded address, a flag that at least one entry matched, the number of matching entries, and the captured vector itself. Each later `next` pulse moves the encoded address to the next higher matching entry. Once no higher entry remains, the found flag drops.

The parameter `GATHER_CYCLES` selects how the vector is gathered.

- With a value of 1, the whole vector is taken on the `start` edge.
- With a value of 2, the even-indexed bits are taken on the `start` edge and the odd-indexed bits on the following edge. `busy` is high between those two edges.

The parameter `SINGLE_HIT` configures the block for arrays that are meant to hold at most one match per search. In that configuration the count is reduced to a 0/1 flag.

Top module: `cam_hit_walker`

## Requirements
- R1: While reset is applied and afterwards until the first search, `hit_addr`, `hit_count`, `hit_bits`, `found` and `busy` are all zero.
- R2: With `GATHER_CYCLES`=1, a `start` sampled at a rising edge makes `found`, `hit_addr` (the lowest set index of `match_vec`) and `hit_count` valid right after that same edge.
- R3: A `next` sampled while `found` is high, with `start` and `busy` low, moves `hit_addr` to the lowest matching index strictly above the current one. Repeated `next` pulses visit every match in ascending order.
- R4: A `next` sampled when no higher match remains clears `found` and leaves `hit_addr` unchanged. Further `next` pulses change nothing until the next `start`.
- R5: With `SINGLE_HIT`=0, `hit_count` equals the number of ones in the captured vector, and it stays constant while walking.
- R6: `hit_bits` presents the captured vector (bit i is entry i) from the moment a search completes until the next search completes.
- R7: A search over an all-zero vector gives `found`=0, `hit_count`=0 and `hit_addr`=0.
- R8: With `GATHER_CYCLES`=2, the even-indexed bits (0, 2, 4, ...) come from `match_vec` at the `start` edge and the odd-indexed bits from the following edge. The outputs change only after that second edge.
- R9: With `GATHER_CYCLES`=2, `busy` is high for exactly the one cycle between the `start` edge and the completing edge. With `GATHER_CYCLES`=1, `busy` stays low.
- R10: A `next` sampled while `busy` is high is ignored.
- R11: With `SINGLE_HIT`=1, `hit_count` is 1 when any entry matched and 0 otherwise.
- R12: When `start` and `next` are both sampled high, `start` wins: a fresh search begins and the walk is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| match_vec | input | ENTRIES | Raw per-entry match bits from the array |
| start | input | 1 | Begin a new search |
| next | input | 1 | Advance to the next higher match |
| hit_addr | output | $clog2(ENTRIES) | Encoded address of the current match |
| found | output | 1 | A current match is being presented |
| hit_count | output | $clog2(ENTRIES+1) | Number of matches in the search |
| hit_bits | output | ENTRIES | Captured unencoded match vector |
| busy | output | 1 | Split gather in progress |

## Verification
The main walk is run over these vectors:

- three matches at 0, 6 and 10;
- the two-match case at 6 and 10;
- an empty vector;
- a lone match in the top entry;
- a lone match in entry 0;
- an all-ones vector;
- a checkerboard.

Together they separate the lowest-first ordering, the exhaustion at the top of the array, the empty result and the count saturating at full width. The split gather is given a different vector on each of its two edges, so a design that took either half from the wrong edge produces a visibly different captured vector. A `next` raised in the busy cycle and one raised together with `start` show the two priority rules. A copy configured for single hits, driven by the same vectors, shows the count reduced to a flag.

// File: rtl/cam_walk_pkg.sv
package cam_walk_pkg;
   typedef enum logic {PH_IDLE = 1'b0, PH_ODD = 1'b1} gather_ph_t;
endpackage

// File: rtl/hit_gather.sv
module hit_gather #(
   parameter int ENTRIES       = 16,
   parameter int GATHER_CYCLES = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [ENTRIES-1:0] vec,
   output logic               done,
   output logic               busy,
   output logic [ENTRIES-1:0] full
);
   import cam_walk_pkg::*;

   generate
      if (GATHER_CYCLES == 1) begin : g_one
         assign done = start;
         assign busy = 1'b0;
         assign full = vec;
      end else begin : g_two
         logic [ENTRIES-1:0] even_sel;
         logic [ENTRIES-1:0] even_q;
         gather_ph_t         ph;

         for (genvar i = 0; i < ENTRIES; i++) begin : g_sel
            assign even_sel[i] = ((i % 2) == 0);
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               even_q <= '0;
               ph     <= PH_IDLE;
            end else if (start) begin
               even_q <= vec & even_sel;
               ph     <= PH_ODD;
            end else begin
               ph     <= PH_IDLE;
            end
         end

         assign busy = (ph == PH_ODD);
         assign done = busy && !start;
         assign full = even_q | (vec & ~even_sel);

         AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
            start |=> busy);                                   // R9
         AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
            (busy && !start) |=> !busy);                       // R9
      end
   endgenerate
endmodule

// File: rtl/hit_pick.sv
module hit_pick #(
   parameter int ENTRIES = 16,
   localparam int AW     = $clog2(ENTRIES)
) (
   input  logic [ENTRIES-1:0] vec,
   input  logic               floor_en,
   input  logic [AW-1:0]      floor_idx,
   output logic               any,
   output logic [AW-1:0]      idx
);
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (vec[i] && (!floor_en || (AW'(i) > floor_idx))) begin
            any = 1'b1;
            idx = AW'(i);
         end
      end
   end
endmodule

// File: rtl/hit_popcount.sv
module hit_popcount #(
   parameter int ENTRIES = 16,
   localparam int CW     = $clog2(ENTRIES + 1)
) (
   input  logic [ENTRIES-1:0] vec,
   output logic [CW-1:0]      cnt
);
   always_comb begin
      cnt = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         cnt = cnt + CW'(vec[i]);
      end
   end
endmodule

// File: rtl/cam_hit_walker.sv
module cam_hit_walker #(
   parameter int ENTRIES       = 16,
   parameter int GATHER_CYCLES = 1,
   parameter bit SINGLE_HIT    = 1'b0,
   localparam int AW           = $clog2(ENTRIES),
   localparam int CW           = $clog2(ENTRIES + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ENTRIES-1:0] match_vec,
   input  logic               start,
   input  logic               next,
   output logic [AW-1:0]      hit_addr,
   output logic               found,
   output logic [CW-1:0]      hit_count,
   output logic [ENTRIES-1:0] hit_bits,
   output logic               busy
);
   generate
      if (ENTRIES < 2) begin : g_bad_depth
         $error("ENTRIES must be at least 2");
      end
      if (GATHER_CYCLES != 1 && GATHER_CYCLES != 2) begin : g_bad_lat
         $error("GATHER_CYCLES must be 1 or 2");
      end
      if (GATHER_CYCLES == 2 && (ENTRIES % 2) != 0) begin : g_bad_split
         $error("split gather needs an even ENTRIES");
      end
   endgenerate

   logic               done_w;
   logic [ENTRIES-1:0] full_w;
   logic               new_any, nx_any;
   logic [AW-1:0]      new_idx, nx_idx;
   logic [CW-1:0]      new_cnt;
   logic [ENTRIES-1:0] snap_q;
   logic               next_ok;

   hit_gather #(.ENTRIES(ENTRIES), .GATHER_CYCLES(GATHER_CYCLES)) u_gather (
      .clk(clk), .rst_n(rst_n), .start(start), .vec(match_vec),
      .done(done_w), .busy(busy), .full(full_w));

   hit_pick #(.ENTRIES(ENTRIES)) u_first (
      .vec(full_w), .floor_en(1'b0), .floor_idx(hit_addr),
      .any(new_any), .idx(new_idx));

   hit_pick #(.ENTRIES(ENTRIES)) u_step (
      .vec(snap_q), .floor_en(1'b1), .floor_idx(hit_addr),
      .any(nx_any), .idx(nx_idx));

   generate
      if (SINGLE_HIT) begin : g_flag_count
         assign new_cnt = CW'(new_any);
      end else begin : g_full_count
         hit_popcount #(.ENTRIES(ENTRIES)) u_pop (.vec(full_w), .cnt(new_cnt));
      end
   endgenerate

   assign next_ok = next && !start && !busy && found;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap_q    <= '0;
         hit_addr  <= '0;
         found     <= 1'b0;
         hit_count <= '0;
      end else if (done_w) begin
         snap_q    <= full_w;
         hit_addr  <= new_idx;
         found     <= new_any;
         hit_count <= new_cnt;
      end else if (next_ok) begin
         if (nx_any) hit_addr <= nx_idx;
         else        found    <= 1'b0;
      end
   end

   assign hit_bits = snap_q;

   AST_FOUND_MARKS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      found |-> hit_bits[hit_addr]);                                 // R2
   AST_NEXT_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(next_ok) && found) |-> (hit_addr > $past(hit_addr)));   // R3
   AST_EXHAUST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!done_w) && !found) |-> (hit_addr == $past(hit_addr))); // R4
   AST_FOUND_HAS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      found |-> (hit_count != '0));                                  // R5
   AST_WALK_KEEPS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(done_w) |-> $stable(hit_bits));                         // R6

   generate
      if (SINGLE_HIT) begin : g_single_chk
         AST_SINGLE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
            hit_count <= CW'(1));                                    // R11
      end
   endgenerate
endmodule

// File: tb/tb_cam_hit_walker.sv
module tb_cam_hit_walker;
   localparam int N  = 16;
   localparam int AW = $clog2(N);
   localparam int CW = $clog2(N + 1);
   localparam int NV = 7;
   localparam logic [N-1:0] VECS [NV] = '{16'h0441, 16'h0440, 16'h0000,
                                          16'h8000, 16'h0001, 16'hFFFF, 16'hA5A5};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [N-1:0] vec = '0, vec2 = '0;
   logic start = 1'b0, next = 1'b0, start2 = 1'b0, next2 = 1'b0;
   logic [AW-1:0] a1, a2, as;
   logic f1, f2, fs, b1, b2, bs;
   logic [CW-1:0] c1, c2, cs;
   logic [N-1:0] h1, h2, hs;

   cam_hit_walker #(.ENTRIES(N), .GATHER_CYCLES(1), .SINGLE_HIT(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .match_vec(vec), .start(start), .next(next),
      .hit_addr(a1), .found(f1), .hit_count(c1), .hit_bits(h1), .busy(b1));
   cam_hit_walker #(.ENTRIES(N), .GATHER_CYCLES(2), .SINGLE_HIT(1'b0)) dut2 (
      .clk(clk), .rst_n(rst_n), .match_vec(vec2), .start(start2), .next(next2),
      .hit_addr(a2), .found(f2), .hit_count(c2), .hit_bits(h2), .busy(b2));
   cam_hit_walker #(.ENTRIES(N), .GATHER_CYCLES(1), .SINGLE_HIT(1'b1)) dut_s (
      .clk(clk), .rst_n(rst_n), .match_vec(vec), .start(start), .next(next),
      .hit_addr(as), .found(fs), .hit_count(cs), .hit_bits(hs), .busy(bs));

   int checks = 0, fails = 0;

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic pulse_start(input logic [N-1:0] v, input logic with_next);
      @(negedge clk);
      vec = v; start = 1'b1; next = with_next;
      @(negedge clk);
      start = 1'b0; next = 1'b0;
   endtask

   task automatic pulse_next();
      @(negedge clk); next = 1'b1;
      @(negedge clk); next = 1'b0;
   endtask

   initial begin
      #(8 * 100000);
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 addr", a1, 0); chk("R1 found", f1, 0); chk("R1 count", c1, 0);
      chk("R1 bits", h1, 0); chk("R1 busy", b2, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 found after", f2, 0); chk("R1 bits after", h2, 0);

      for (int k = 0; k < NV; k++) begin
         logic [N-1:0] v;
         int pop, first, last;
         v = VECS[k];
         pop = 0; first = 0; last = 0;
         for (int i = N - 1; i >= 0; i--) if (v[i]) begin pop++; first = i; end
         pulse_start(v, 1'b0);
         chk(pop == 0 ? "R7 found" : "R2 found", f1, pop > 0);
         chk(pop == 0 ? "R7 addr" : "R2 addr", a1, first);
         chk("R5 count", c1, pop);
         chk("R6 bits", h1, v);
         chk("R9 no busy", b1, 0);
         chk("R11 single count", cs, pop > 0);
         last = first;
         for (int i = first + 1; i < N; i++) begin
            if (v[i] && pop > 0) begin
               pulse_next();
               chk("R3 addr", a1, i); chk("R3 found", f1, 1);
               chk("R5 count stable", c1, pop);
               last = i;
            end
         end
         pulse_next();
         chk("R4 found low", f1, 0); chk("R4 addr held", a1, last);
         pulse_next();
         chk("R4 found stays", f1, 0); chk("R4 addr stays", a1, last);
         chk("R6 bits kept", h1, v);
      end

      // R12: start with next in the same cycle
      pulse_start(16'h0441, 1'b0);
      pulse_next();
      chk("R12 setup", a1, 6);
      pulse_start(16'h0441, 1'b1);
      chk("R12 restart addr", a1, 0); chk("R12 restart found", f1, 1);

      // R8, R9: split gather with different halves on each edge
      @(negedge clk); vec2 = 16'h0F0F; start2 = 1'b1;
      @(negedge clk); start2 = 1'b0; vec2 = 16'hF0F0;
      chk("R9 busy high", b2, 1); chk("R8 not yet found", f2, 0);
      @(negedge clk); vec2 = 16'h0000;
      chk("R9 busy low", b2, 0);
      chk("R8 bits", h2, 16'hA5A5); chk("R8 addr", a2, 0);
      chk("R8 count", c2, 8); chk("R8 found", f2, 1);
      @(negedge clk); next2 = 1'b1;
      @(negedge clk); next2 = 1'b0;
      chk("R3 split walk", a2, 2);

      // R10: next during busy is ignored
      @(negedge clk); vec2 = 16'h0440; start2 = 1'b1;
      @(negedge clk); start2 = 1'b0; next2 = 1'b1;
      chk("R10 addr during busy", a2, 2);
      @(negedge clk); next2 = 1'b0;
      chk("R10 addr first", a2, 6); chk("R10 count", c2, 2);
      @(negedge clk); next2 = 1'b1;
      @(negedge clk); next2 = 1'b0;
      chk("R3 ten after six", a2, 10);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule